// File: doc/BRIEF.md
# Fuse-Configured Programmable Logic Macrocell Core

This block models a small sum-of-products programmable logic device. Sixteen array signals, each offered in true and complemented form, feed 64 product terms. The terms are split into eight groups of eight, and each group belongs to one output macrocell. A macrocell combines its terms, applies a programmable polarity, and then either drives its pin straight from the logic or stores the result in a flip-flop. The whole personality sits in a 2194-bit configuration vector. The vector is shifted in serially, one bit per rising clock edge, and each bit can be read back by address.

A three-state controller sequences configuration. In `CFG_BLANK` the device holds no valid personality. Raising the load input moves it to `CFG_SHIFT`, where it shifts one bit per edge. When load falls, it moves to `CFG_RUN` if at least 2194 bits arrived, and otherwise back to `CFG_BLANK`. Raising load in `CFG_RUN` returns it to `CFG_SHIFT`. Pins are driven only in `CFG_RUN`, and all macrocell flip-flops are held clear outside it.

Two global bits choose one of three device modes. Simple mode gives plain combinational outputs or inputs. Complex mode gives combinational outputs, each with its own product-term output enable. Registered mode allows flip-flop outputs clocked from the clock pin, enabled by a shared active-low pin. In simple and complex modes the clock pin and the enable pin are ordinary array inputs that take the place of selected macrocell feedbacks.

Top module: `pld_core`

## Requirements
- R1: After reset the configuration vector is all zero and every `io_oe` bit is 0. Every `io_oe` bit stays 0 in every state other than `CFG_RUN`.
- R2: While `cfg_load` is high, one bit is taken from `cfg_sin` on each rising edge, and the first bit shifted lands at address 0. If `cfg_load` falls after fewer than 2194 bits, the device returns to the unconfigured state with outputs disabled. Starting a new load from `CFG_RUN` disables all outputs at once.
- R3: `cfg_rdata` shows the configuration bit at address `cfg_raddr`. Addresses of 2194 and above read 0.
- R4: When the security bit at address 2056 is 1, addresses 0 to 2047 read 0. All other addresses still read their stored value.
- R5: Product term r uses fuse addresses 32r to 32r+31. Column 2k is the true form of signal k and column 2k+1 is its complement. A fuse at 0 connects its literal, and the term is the AND of the connected literals. A term with every fuse at 1 is 1. The enable bit at 2128+r must be 1, otherwise the term is 0. Macrocell m owns terms 8m to 8m+7.
- R6: Signals 0 to 7 are `ded_in[7:0]`. Signal 8+m is the feedback of macrocell m: the flip-flop output value for a registered macrocell, and `io_in[m]` for every other macrocell.
- R7: The polarity bit of macrocell m is at 2048+m. A value of 1 drives the sum unchanged and 0 drives it inverted.
- R8: The mode bits are at 2192 and 2193. The value 1,0 selects simple mode, 1,1 complex and 0,1 registered. The value 0,0 keeps every output disabled.
- R9: In simple mode a macrocell ORs all eight terms. Its bit at 2120+m set to 0 makes it an output and set to 1 makes it an input only. Macrocells 3 and 4 are always outputs, and their feedback signals 11 and 12 are replaced by `clk_pin` and `oe_pin_n`.
- R10: In complex mode term 0 of each macrocell is its output enable and terms 1 to 7 form the OR. Feedback signals 8 and 15 are replaced by `clk_pin` and `oe_pin_n`.
- R11: In registered mode a macrocell with its 2120+m bit at 0 is registered. On each rising `clk_pin` edge it captures the polarity-adjusted OR of all eight terms, and `io_oe` equals the inverse of `oe_pin_n`. A macrocell with the bit at 1 behaves as in R10.
- R12: The flip-flops clear on reset and outside `CFG_RUN`. Right after a load, every enabled registered pin reads 1 whatever its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin | input | 1 | Device clock for configuration and flip-flops; an array input in simple and complex modes |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| oe_pin_n | input | 1 | Shared active-low output enable in registered mode; an array input otherwise |
| ded_in | input | 8 | Dedicated array inputs, signals 0 to 7 |
| io_in | input | 8 | Value seen on each bidirectional pin |
| io_out | output | 8 | Value driven on each bidirectional pin |
| io_oe | output | 8 | Drive enable for each bidirectional pin |
| cfg_load | input | 1 | High while configuration bits are being shifted |
| cfg_sin | input | 1 | Serial configuration data, lowest address first |
| cfg_raddr | input | 12 | Readback address |
| cfg_rdata | output | 1 | Readback data bit |

## Verification
The hardest condition to reach from the ports is the one where the clock pin acts as a logic input in simple and complex modes. The bench first loads the vector with a free-running clock. It then stops the generator and drives `clk_pin` as a plain data level, so that its substitution for the macrocell feedbacks shows up in the combinational outputs. In registered mode, the bench keeps its own model of each flip-flop, including a self-toggling one fed from its own output. The first sample after the load checks the high power-up level on an active-high pin and an inverted pin alike.

// File: rtl/pld_pkg.sv
package pld_pkg;
    localparam int N_SIG      = 16;
    localparam int N_MC       = 8;
    localparam int PT_PER_MC  = 8;
    localparam int N_DED      = N_SIG - N_MC;
    localparam int N_COL      = 2 * N_SIG;
    localparam int N_PT       = N_MC * PT_PER_MC;
    localparam int ARRAY_BITS = N_PT * N_COL;
    localparam int SPARE_BITS = 64;
    localparam int XOR_BASE   = ARRAY_BITS;
    localparam int SEC_ADDR   = XOR_BASE + N_MC;
    localparam int AC1_BASE   = XOR_BASE + N_MC + SPARE_BITS;
    localparam int PTD_BASE   = AC1_BASE + N_MC;
    localparam int SYN_ADDR   = PTD_BASE + N_PT;
    localparam int AC0_ADDR   = SYN_ADDR + 1;
    localparam int CFG_BITS   = AC0_ADDR + 1;
    localparam int ADDR_W     = $clog2(CFG_BITS);
    localparam int CNT_W      = $clog2(CFG_BITS + 1);
    localparam int CTR_LO     = N_MC / 2 - 1;
    localparam int CTR_HI     = N_MC / 2;

    typedef enum logic [1:0] {
        MODE_SIMPLE,
        MODE_COMPLEX,
        MODE_REGISTERED,
        MODE_INVALID
    } dev_mode_e;

    typedef enum logic [1:0] {
        CFG_BLANK,
        CFG_SHIFT,
        CFG_RUN
    } cfg_state_e;
endpackage

// File: rtl/pld_cfg_ctrl.sv
module pld_cfg_ctrl
    import pld_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                sin,
    input  logic [ADDR_W-1:0]   raddr,
    output logic                rdata,
    output logic [CFG_BITS-1:0] cfg,
    output logic                run
);
    cfg_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [CFG_BITS-1:0] cfg_q;
    logic                full;

    assign full = (cnt_q == CNT_W'(CFG_BITS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_BLANK;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_BLANK: if (load)  state_d = CFG_SHIFT;
            CFG_SHIFT: if (!load) state_d = full ? CFG_RUN : CFG_BLANK;
            CFG_RUN:   if (load)  state_d = CFG_SHIFT;
            default:              state_d = CFG_BLANK;
        endcase
    end

    // shift register and bit counter (saturating at the vector length)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            cfg_q <= {sin, cfg_q[CFG_BITS-1:1]};
            if (state_q != CFG_SHIFT) cnt_q <= CNT_W'(1);
            else if (!full)           cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        run   = (state_q == CFG_RUN);
        cfg   = cfg_q;
        rdata = 1'b0;
        if (raddr < ADDR_W'(CFG_BITS)) begin
            if (!(cfg_q[SEC_ADDR] && (raddr < ADDR_W'(ARRAY_BITS))))
                rdata = cfg_q[raddr];
        end
    end
endmodule

// File: rtl/pld_and_array.sv
module pld_and_array
    import pld_pkg::*;
(
    input  logic [N_SIG-1:0]      sig,
    input  logic [ARRAY_BITS-1:0] fuse,
    input  logic [N_PT-1:0]       pt_en,
    output logic [N_PT-1:0]       pterm
);
    logic [N_COL-1:0] lit;

    always_comb begin
        for (int k = 0; k < N_SIG; k++) begin
            lit[2*k]   = sig[k];
            lit[2*k+1] = ~sig[k];
        end
    end

    // a fuse at 1 is open and lets the column pass as true
    for (genvar r = 0; r < N_PT; r++) begin : g_row
        assign pterm[r] = pt_en[r] & (&(fuse[r*N_COL +: N_COL] | lit));
    end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import pld_pkg::*;
#(
    parameter bit ALWAYS_OUT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  dev_mode_e            mode,
    input  logic [PT_PER_MC-1:0] terms,
    input  logic                 pol,
    input  logic                 ac1,
    input  logic                 oe_pin_n,
    input  logic                 pin_in,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb,
    output logic                 is_reg
);
    logic q;
    logic sum;

    always_comb begin
        is_reg = (mode == MODE_REGISTERED) && !ac1;
        if (is_reg || mode == MODE_SIMPLE) sum = |terms;
        else                               sum = |terms[PT_PER_MC-1:1];
    end

    // the stored bit is the inverse of what the pin shows
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= 1'b0;
        else if (!run)   q <= 1'b0;
        else if (is_reg) q <= sum ^ pol;
    end

    always_comb begin
        pin_out = is_reg ? ~q : (pol ? sum : ~sum);
        fb      = is_reg ? ~q : pin_in;
        pin_oe  = 1'b0;
        if (run) begin
            unique case (mode)
                MODE_SIMPLE:     pin_oe = ALWAYS_OUT ? 1'b1 : ~ac1;
                MODE_COMPLEX:    pin_oe = terms[0];
                MODE_REGISTERED: pin_oe = is_reg ? ~oe_pin_n : terms[0];
                default:         pin_oe = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pld_core.sv
module pld_core
    import pld_pkg::*;
(
    input  logic              clk_pin,
    input  logic              rst_n,
    input  logic              oe_pin_n,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_MC-1:0]   io_in,
    output logic [N_MC-1:0]   io_out,
    output logic [N_MC-1:0]   io_oe,
    input  logic              cfg_load,
    input  logic              cfg_sin,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic              cfg_rdata
);
    logic [CFG_BITS-1:0] cfg;
    logic                run;
    dev_mode_e           mode;
    logic [N_SIG-1:0]    sig;
    logic [N_PT-1:0]     pterm;
    logic [N_MC-1:0]     fb;
    logic [N_MC-1:0]     reg_mask;

    pld_cfg_ctrl u_ctrl (
        .clk   (clk_pin),
        .rst_n (rst_n),
        .load  (cfg_load),
        .sin   (cfg_sin),
        .raddr (cfg_raddr),
        .rdata (cfg_rdata),
        .cfg   (cfg),
        .run   (run)
    );

    always_comb begin
        unique case ({cfg[SYN_ADDR], cfg[AC0_ADDR]})
            2'b10:   mode = MODE_SIMPLE;
            2'b11:   mode = MODE_COMPLEX;
            2'b01:   mode = MODE_REGISTERED;
            default: mode = MODE_INVALID;
        endcase
    end

    assign sig[N_DED-1:0] = ded_in;

    pld_and_array u_array (
        .sig   (sig),
        .fuse  (cfg[ARRAY_BITS-1:0]),
        .pt_en (cfg[PTD_BASE +: N_PT]),
        .pterm (pterm)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        localparam bit CENTER = (m == CTR_LO) || (m == CTR_HI);
        localparam bit OUTER  = (m == 0) || (m == N_MC - 1);
        logic sub_pin;

        // lower half takes the clock pin, upper half the enable pin
        assign sub_pin = (m < N_MC / 2) ? clk_pin : oe_pin_n;
        assign sig[N_DED+m] = ((mode == MODE_SIMPLE && CENTER) ||
                               (mode == MODE_COMPLEX && OUTER)) ? sub_pin : fb[m];

        pld_macrocell #(.ALWAYS_OUT(CENTER)) u_mc (
            .clk      (clk_pin),
            .rst_n    (rst_n),
            .run      (run),
            .mode     (mode),
            .terms    (pterm[m*PT_PER_MC +: PT_PER_MC]),
            .pol      (cfg[XOR_BASE+m]),
            .ac1      (cfg[AC1_BASE+m]),
            .oe_pin_n (oe_pin_n),
            .pin_in   (io_in[m]),
            .pin_out  (io_out[m]),
            .pin_oe   (io_oe[m]),
            .fb       (fb[m]),
            .is_reg   (reg_mask[m])
        );
    end
endmodule

// File: rtl/pld_core_chk.sv
module pld_core_chk
    import pld_pkg::*;
(
    input logic                clk_pin,
    input logic                rst_n,
    input logic                run,
    input dev_mode_e           mode,
    input logic [N_MC-1:0]     reg_mask,
    input logic                oe_pin_n,
    input logic [N_MC-1:0]     io_oe,
    input logic [N_MC-1:0]     io_out,
    input logic [CFG_BITS-1:0] cfg
);
    p_oe_off_unconfigured_r1: assert property (@(posedge clk_pin) disable iff (!rst_n)
        !run |-> (io_oe == '0));

    p_cfg_frozen_in_run_r2: assert property (@(posedge clk_pin) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(cfg));

    p_invalid_mode_quiet_r8: assert property (@(posedge clk_pin) disable iff (!rst_n)
        (mode == MODE_INVALID) |-> (io_oe == '0));

    p_center_driven_r9: assert property (@(posedge clk_pin) disable iff (!rst_n)
        (run && mode == MODE_SIMPLE) |-> (io_oe[CTR_LO] && io_oe[CTR_HI]));

    p_shared_enable_r11: assert property (@(posedge clk_pin) disable iff (!rst_n)
        (run && mode == MODE_REGISTERED) |->
            ((io_oe & reg_mask) == (oe_pin_n ? '0 : reg_mask)));

    p_powerup_high_r12: assert property (@(posedge clk_pin) disable iff (!rst_n)
        (run && !$past(run)) |-> ((io_out & reg_mask) == reg_mask));
endmodule

bind pld_core pld_core_chk u_chk (
    .clk_pin  (clk_pin),
    .rst_n    (rst_n),
    .run      (run),
    .mode     (mode),
    .reg_mask (reg_mask),
    .oe_pin_n (oe_pin_n),
    .io_oe    (io_oe),
    .io_out   (io_out),
    .cfg      (cfg)
);

// File: tb/pld_core_tb.sv
module pld_core_tb_top;
    localparam int CLK_P = 10;
    localparam int NB    = 2194;
    localparam int A_XOR = 2048;
    localparam int A_SEC = 2056;
    localparam int A_AC1 = 2120;
    localparam int A_PTD = 2128;
    localparam int A_SYN = 2192;
    localparam int A_AC0 = 2193;

    logic        clk_pin = 1'b0;
    logic        clk_free = 1'b1;
    logic        rst_n = 1'b0;
    logic        oe_pin_n = 1'b0;
    logic [7:0]  ded_in = '0;
    logic [7:0]  io_in = '0;
    logic [7:0]  io_out, io_oe;
    logic        cfg_load = 1'b0;
    logic        cfg_sin = 1'b0;
    logic [11:0] cfg_raddr = '0;
    logic        cfg_rdata;
    logic [NB-1:0] img;
    int n_chk = 0;
    int n_fail = 0;

    pld_core dut_i (
        .clk_pin(clk_pin), .rst_n(rst_n), .oe_pin_n(oe_pin_n), .ded_in(ded_in),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .cfg_load(cfg_load),
        .cfg_sin(cfg_sin), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
    );

    always begin
        #(CLK_P/2);
        if (clk_free) clk_pin = ~clk_pin;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic img_blank();
        img = '0;
        for (int a = 0; a < 2048; a++) img[a] = 1'b1;
        for (int m = 0; m < 8; m++) img[A_AC1+m] = 1'b1;
    endtask

    task automatic img_term(input int mc, input int t, input logic [15:0] pos, input logic [15:0] neg);
        int row;
        row = mc*8 + t;
        for (int k = 0; k < 16; k++) begin
            img[row*32+2*k]   = ~pos[k];
            img[row*32+2*k+1] = ~neg[k];
        end
        img[A_PTD+row] = 1'b1;
    endtask

    task automatic shift_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_pin);
            cfg_load = 1'b1;
            cfg_sin  = img[i];
        end
        @(negedge clk_pin);
        cfg_load = 1'b0;
    endtask

    task automatic full_load();
        shift_bits(NB);
        @(negedge clk_pin);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk_pin);
        check("R1 oe in reset", {24'b0, io_oe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk_pin);
        check("R1 oe after reset", {24'b0, io_oe}, 32'h0);
        cfg_raddr = 12'd2192;
        #1 check("R1 cleared vector", {31'b0, cfg_rdata}, 32'h0);
    endtask

    task automatic t_simple();
        logic [7:0] eo, ev;
        img_blank();
        img_term(0, 0, 16'h0001, 16'h0002); img[A_XOR+0] = 1'b1; img[A_AC1+0] = 1'b0;
        img_term(1, 0, 16'h0004, 16'h0000); img_term(1, 1, 16'h0008, 16'h0000);
        img[A_XOR+1] = 1'b0; img[A_AC1+1] = 1'b0;
        img_term(3, 0, 16'h0810, 16'h0000); img[A_XOR+3] = 1'b1;
        img_term(4, 0, 16'h0020, 16'h0000); img[A_PTD+32] = 1'b0; img[A_XOR+4] = 1'b1;
        img_term(5, 0, 16'h0400, 16'h0000); img[A_XOR+5] = 1'b1; img[A_AC1+5] = 1'b0;
        img[A_SYN] = 1'b1; img[A_AC0] = 1'b0;
        full_load();
        clk_free = 1'b0;
        for (int v = 0; v < 128; v++) begin
            ded_in = {2'b0, v[0] ^ v[3], v[4:0]};
            clk_pin = v[5];
            io_in = {5'b0, v[6], 2'b0};
            #(CLK_P/4);
            eo = 8'h3B;
            ev = '0;
            ev[0] = v[0] & ~v[1];
            ev[1] = ~(v[2] | v[3]);
            ev[3] = v[5] & v[4];
            ev[4] = 1'b0;
            ev[5] = v[6];
            check("R9 R5 R6 R7 simple mode", {16'b0, io_oe, io_out & io_oe}, {16'b0, eo, ev & eo});
        end
        clk_pin = 1'b0;
        #(CLK_P/4);
        clk_free = 1'b1;
    endtask

    task automatic t_complex();
        logic [7:0] eo, ev;
        img_blank();
        img_term(0, 0, 16'h0080, 16'h0000); img_term(0, 1, 16'h0003, 16'h0000); img[A_XOR+0] = 1'b0;
        img_term(1, 0, 16'h0000, 16'h0000); img_term(1, 1, 16'h0104, 16'h0000); img[A_XOR+1] = 1'b1;
        img_term(2, 0, 16'h0000, 16'h0000); img_term(2, 1, 16'h8008, 16'h0000); img[A_XOR+2] = 1'b1;
        img_term(3, 0, 16'h0000, 16'h0000); img_term(3, 1, 16'h1000, 16'h0000); img[A_XOR+3] = 1'b1;
        img[A_SYN] = 1'b1; img[A_AC0] = 1'b1;
        full_load();
        clk_free = 1'b0;
        for (int v = 0; v < 256; v++) begin
            ded_in = {v[4], 3'b0, v[3:0]};
            clk_pin = v[5];
            oe_pin_n = v[6];
            io_in = {3'b0, v[7], 4'b0};
            #(CLK_P/4);
            eo = {4'b0, 3'b111, v[4]};
            ev = '0;
            ev[0] = ~(v[0] & v[1]);
            ev[1] = v[5] & v[2];
            ev[2] = v[6] & v[3];
            ev[3] = v[7];
            check("R10 complex mode", {16'b0, io_oe, io_out & io_oe}, {16'b0, eo, ev & eo});
        end
        clk_pin = 1'b0;
        oe_pin_n = 1'b0;
        #(CLK_P/4);
        clk_free = 1'b1;
    endtask

    task automatic t_readback();
        for (int a = 0; a < NB; a += 97) begin
            cfg_raddr = 12'(a);
            #1 check("R3 R2 readback", {31'b0, cfg_rdata}, {31'b0, img[a]});
        end
        for (int a = A_XOR; a < A_XOR + 8; a++) begin
            cfg_raddr = 12'(a);
            #1 check("R3 polarity readback", {31'b0, cfg_rdata}, {31'b0, img[a]});
        end
        cfg_raddr = 12'(A_AC0);
        #1 check("R3 mode bit readback", {31'b0, cfg_rdata}, 32'h1);
        cfg_raddr = 12'd4000;
        #1 check("R3 out of range", {31'b0, cfg_rdata}, 32'h0);
    endtask

    task automatic t_secure();
        img[A_SEC] = 1'b1;
        full_load();
        for (int a = 0; a < 2048; a += 61) begin
            cfg_raddr = 12'(a);
            #1 check("R4 protected array", {31'b0, cfg_rdata}, 32'h0);
        end
        for (int a = A_XOR; a < A_XOR + 8; a++) begin
            cfg_raddr = 12'(a);
            #1 check("R4 unprotected field", {31'b0, cfg_rdata}, {31'b0, img[a]});
        end
        cfg_raddr = 12'(A_SEC);
        #1 check("R4 security bit", {31'b0, cfg_rdata}, 32'h1);
    endtask

    task automatic img_registered();
        img_blank();
        img_term(0, 0, 16'h0000, 16'h0100); img[A_XOR+0] = 1'b1; img[A_AC1+0] = 1'b0;
        img_term(1, 0, 16'h0001, 16'h0000); img[A_XOR+1] = 1'b0; img[A_AC1+1] = 1'b0;
        img_term(2, 0, 16'h0002, 16'h0000); img_term(2, 1, 16'h0104, 16'h0000); img[A_XOR+2] = 1'b1;
        img_term(3, 7, 16'h0008, 16'h0000); img[A_XOR+3] = 1'b1; img[A_AC1+3] = 1'b0;
        img[A_SYN] = 1'b0; img[A_AC0] = 1'b1;
    endtask

    task automatic t_registered();
        logic p0, p1, p3;
        logic [7:0] d, eo, ev;
        img_registered();
        oe_pin_n = 1'b0;
        ded_in = '0;
        full_load();
        p0 = 1'b1; p1 = 1'b1; p3 = 1'b1;
        for (int i = 0; i < 14; i++) begin
            d = 8'(i*37 + 5);
            ded_in = d;
            oe_pin_n = (i == 6 || i == 7);
            #1;
            eo = '0;
            eo[0] = ~oe_pin_n; eo[1] = ~oe_pin_n; eo[3] = ~oe_pin_n; eo[2] = d[1];
            ev = '0;
            ev[0] = p0; ev[1] = p1; ev[2] = p0 & d[2]; ev[3] = p3;
            if (i == 0)
                check("R12 power-up high", {16'b0, io_oe, io_out & io_oe}, {16'b0, eo, ev & eo});
            else
                check("R11 registered mode", {16'b0, io_oe, io_out & io_oe}, {16'b0, eo, ev & eo});
            @(negedge clk_pin);
            p0 = ~p0;
            p1 = ~d[0];
            p3 = d[3];
        end
        oe_pin_n = 1'b0;
    endtask

    task automatic t_partial();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_pin);
            cfg_load = 1'b1;
            cfg_sin  = img[i];
        end
        check("R2 outputs off while shifting", {24'b0, io_oe}, 32'h0);
        @(negedge clk_pin);
        cfg_load = 1'b0;
        repeat (2) @(negedge clk_pin);
        check("R2 short load stays blank", {24'b0, io_oe}, 32'h0);
    endtask

    task automatic t_badmode();
        img_registered();
        img[A_AC0] = 1'b0;
        full_load();
        for (int i = 0; i < 3; i++) begin
            ded_in = 8'(i*11);
            #1 check("R8 invalid mode disabled", {24'b0, io_oe}, 32'h0);
            @(negedge clk_pin);
        end
    endtask

    initial begin
        #(CLK_P*150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_simple();
        t_complex();
        t_readback();
        t_secure();
        t_registered();
        t_partial();
        t_badmode();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule